// File: doc/BRIEF.md
# Two-stage watchdog timer

The block is a watchdog that counts down one step per incoming tick pulse from a value that software sets up. Reaching the end of a countdown once does not reset the system. It raises a timeout flag, loads the initial value again and starts a second countdown. Only if that flag is still set when the second countdown ends does the block record a second timeout, record a boot flag, and issue a one-cycle reset request. Software can suppress that request with a no-reboot bit.

Software drives the block through a synchronous register port with byte offsets, a write strobe and 16-bit data. Read data is registered, so it appears one cycle after the address. Software services the watchdog in one of two ways. It can write to the reload offset, which restarts the current countdown. It can also clear the timeout flag, which makes two full countdowns necessary again before a reset.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the halt bit is 1, the no-reboot bit is 1, the initial value is 4, the count is 4, all status flags are 0 and the reset request is 0.
- R2: Register offsets are 0x00 (count), 0x04 (timeout flag at bit 3), 0x06 (second-timeout flag at bit 1, boot flag at bit 2), 0x08 (halt at bit 11, no-reboot at bit 0) and 0x12 (initial value in bits 9:0). Unused bits and unmapped offsets read 0. The read data for an address appears on the cycle after that address is presented.
- R3: While halt is 0, each tick lowers the count by one. While halt is 1, ticks leave the count unchanged.
- R4: A tick that arrives while the count is 0 is an expiry. On a first expiry the timeout flag is set and the count is loaded from the initial value on the same clock edge.
- R5: A write of any data to offset 0x00 loads the count from the initial value. This write takes priority over a tick on the same cycle, and that cycle then produces no expiry.
- R6: A write of 0 to 3 to bits 9:0 of offset 0x12 is ignored and the previous value is kept. A write of 4 or more replaces the value. A new initial value takes effect at the next load of the count.
- R7: An expiry while the timeout flag is set sets the second-timeout and boot flags and reloads the count. If no-reboot is 0, it also pulses the reset request for exactly one cycle, on the same edge that sets those flags.
- R8: While no-reboot is 1 the reset request stays 0, and the status flags are still set. The no-reboot bit reads back as written.
- R9: Writing 1 to a status flag bit clears that flag. Writing 0 to it has no effect.
- R10: A clear of the timeout flag on the same cycle as an expiry makes that expiry a first expiry. The flag stays set and no reset request follows.
- R11: A clear of the second-timeout or boot flag on the same cycle as a second expiry loses to the set, so those flags end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Countdown tick, a single-cycle pulse |
| bus_addr_i | input | 5 | Byte offset of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Registered read data for the previous cycle's address |
| rst_req_o | output | 1 | One-cycle reset request pulse |

## Verification
Three kinds of same-cycle collision matter here. A service action can land on the very cycle of an expiry: a reload write meeting a tick at count 0, or a timeout-flag clear meeting an expiry. A status clear can also coincide with the second-timeout set. The bench steps its state model until the count is 0 and then issues the tick and the conflicting write on the same cycle. On every cycle it compares the reset request and the read-back flags and count with the priorities stated in R5, R10 and R11. A seeded random phase mixes ticks, halts, reloads and clears, so that further collisions arise without being planned.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [4:0] OFS_COUNT = 5'h00;
  localparam logic [4:0] OFS_STS1  = 5'h04;
  localparam logic [4:0] OFS_STS2  = 5'h06;
  localparam logic [4:0] OFS_CTRL  = 5'h08;
  localparam logic [4:0] OFS_INIT  = 5'h12;

  localparam int BIT_TO   = 3;
  localparam int BIT_SEC  = 1;
  localparam int BIT_BOOT = 2;
  localparam int BIT_HALT = 11;
  localparam int BIT_NRB  = 0;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4,
  parameter int INIT_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              to_i,
  input  logic              sec_i,
  input  logic              boot_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CNT_W-1:0]  init_o,
  output logic              halt_o,
  output logic              nrb_o,
  output logic              reload_o,
  output logic              clr_to_o,
  output logic              clr_sec_o,
  output logic              clr_boot_o
);
  logic [CNT_W-1:0]  init_q;
  logic              halt_q, nrb_q;
  logic [DATA_W-1:0] rdata_q, rd_mux;
  logic              hit_cnt, hit_s1, hit_s2, hit_ctl, hit_ini;
  logic              unused_wdata;

  assign hit_cnt = bus_we && (bus_addr == ADDR_W'(OFS_COUNT));
  assign hit_s1  = bus_we && (bus_addr == ADDR_W'(OFS_STS1));
  assign hit_s2  = bus_we && (bus_addr == ADDR_W'(OFS_STS2));
  assign hit_ctl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_ini = bus_we && (bus_addr == ADDR_W'(OFS_INIT));

  assign reload_o   = hit_cnt;
  assign clr_to_o   = hit_s1 && bus_wdata[BIT_TO];
  assign clr_sec_o  = hit_s2 && bus_wdata[BIT_SEC];
  assign clr_boot_o = hit_s2 && bus_wdata[BIT_BOOT];
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      init_q <= CNT_W'(INIT_RST);
      halt_q <= 1'b1;
      nrb_q  <= 1'b1;
    end else begin
      if (hit_ctl) begin
        halt_q <= bus_wdata[BIT_HALT];
        nrb_q  <= bus_wdata[BIT_NRB];
      end
      if (hit_ini && (bus_wdata[CNT_W-1:0] >= CNT_W'(INIT_MIN)))
        init_q <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_W'(OFS_COUNT): rd_mux[CNT_W-1:0] = count_i;
      ADDR_W'(OFS_STS1):  rd_mux[BIT_TO] = to_i;
      ADDR_W'(OFS_STS2): begin
        rd_mux[BIT_SEC]  = sec_i;
        rd_mux[BIT_BOOT] = boot_i;
      end
      ADDR_W'(OFS_CTRL): begin
        rd_mux[BIT_HALT] = halt_q;
        rd_mux[BIT_NRB]  = nrb_q;
      end
      ADDR_W'(OFS_INIT):  rd_mux[CNT_W-1:0] = init_q;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign init_o  = init_q;
  assign halt_o  = halt_q;
  assign nrb_o   = nrb_q;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] init_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] count_q;
  logic             step;

  assign step     = tick_i && !halt_i && !reload_i;
  assign expire_o = step && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst)             count_q <= CNT_W'(INIT_RST);
    else if (reload_i)   count_q <= init_i;
    else if (expire_o)   count_q <= init_i;
    else if (step)       count_q <= count_q - 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/wdog_status.sv
module wdog_status (
  input  logic clk,
  input  logic rst,
  input  logic expire_i,
  input  logic clr_to_i,
  input  logic clr_sec_i,
  input  logic clr_boot_i,
  input  logic nrb_i,
  output logic to_o,
  output logic sec_o,
  output logic boot_o,
  output logic rst_req_o
);
  logic to_q, sec_q, boot_q, req_q;
  logic to_kept, second;

  assign to_kept = to_q && !clr_to_i;
  assign second  = expire_i && to_kept;

  always_ff @(posedge clk) begin
    if (rst) begin
      to_q   <= 1'b0;
      sec_q  <= 1'b0;
      boot_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      to_q   <= expire_i || to_kept;
      sec_q  <= second || (sec_q && !clr_sec_i);
      boot_q <= second || (boot_q && !clr_boot_i);
      req_q  <= second && !nrb_i;
    end
  end

  assign to_o      = to_q;
  assign sec_o     = sec_q;
  assign boot_o    = boot_q;
  assign rst_req_o = req_q;
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 5,
  parameter int CNT_W    = 10,
  parameter int INIT_RST = 4,
  parameter int INIT_MIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_we_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              rst_req_o
);
  logic [CNT_W-1:0] count, init_val;
  logic halt, nrb, reload, clr_to, clr_sec, clr_boot;
  logic expire, to_flag, sec_flag, boot_flag;

  wdog_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .INIT_RST(INIT_RST), .INIT_MIN(INIT_MIN)
  ) regs_i (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr_i), .bus_we(bus_we_i), .bus_wdata(bus_wdata_i),
    .count_i(count), .to_i(to_flag), .sec_i(sec_flag), .boot_i(boot_flag),
    .rdata_o(bus_rdata_o), .init_o(init_val), .halt_o(halt), .nrb_o(nrb),
    .reload_o(reload), .clr_to_o(clr_to), .clr_sec_o(clr_sec),
    .clr_boot_o(clr_boot)
  );

  wdog_counter #(.CNT_W(CNT_W), .INIT_RST(INIT_RST)) cnt_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .halt_i(halt),
    .reload_i(reload), .init_i(init_val), .count_o(count), .expire_o(expire)
  );

  wdog_status sts_i (
    .clk(clk), .rst(rst), .expire_i(expire), .clr_to_i(clr_to),
    .clr_sec_i(clr_sec), .clr_boot_i(clr_boot), .nrb_i(nrb),
    .to_o(to_flag), .sec_o(sec_flag), .boot_o(boot_flag),
    .rst_req_o(rst_req_o)
  );
endmodule

// File: rtl/wdog_two_stage_chk.sv
module wdog_two_stage_chk #(
  parameter int CNT_W    = 10,
  parameter int INIT_MIN = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             rst_req,
  input logic             nrb,
  input logic             halt,
  input logic             reload,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] init_val,
  input logic             to_flag,
  input logic             sec_flag,
  input logic             boot_flag
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);

  a_r7_flags_with_pulse: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (sec_flag && boot_flag));

  a_r8_gate_blocks: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> !$past(nrb));

  a_r4_reload_on_first: assert property (@(posedge clk) disable iff (rst)
    $rose(to_flag) |-> (count == $past(init_val)));

  a_r5_reload_write: assert property (@(posedge clk) disable iff (rst)
    $past(reload) |-> (count == $past(init_val)));

  a_r3_halt_freeze: assert property (@(posedge clk) disable iff (rst)
    ($past(halt) && !$past(reload)) |-> $stable(count));

  a_r6_init_floor: assert property (@(posedge clk) disable iff (rst)
    init_val >= CNT_W'(INIT_MIN));

  a_r7_second_needs_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(sec_flag) |-> $past(to_flag));
endmodule

bind wdog_two_stage wdog_two_stage_chk #(.CNT_W(CNT_W), .INIT_MIN(INIT_MIN)) chk_i (
  .clk(clk), .rst(rst), .rst_req(rst_req_o), .nrb(nrb), .halt(halt),
  .reload(reload), .count(count), .init_val(init_val), .to_flag(to_flag),
  .sec_flag(sec_flag), .boot_flag(boot_flag)
);

// File: tb/wdog_two_stage_tb_top.sv
`timescale 1ns/1ps
module wdog_two_stage_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [4:0]  addr = '0;
  logic        we = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rst_req;

  int checks = 0;
  int fails  = 0;
  int seen_rst = 0;

  logic [9:0] m_cnt = 10'd4, m_init = 10'd4;
  logic m_halt = 1, m_nrb = 1, m_to = 0, m_sec = 0, m_boot = 0, m_rst = 0;

  always #2.5 clk = ~clk;

  wdog_two_stage dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .rst_req_o(rst_req)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [4:0] a);
    logic [15:0] v = '0;
    case (a)
      5'h00: v[9:0] = m_cnt;
      5'h04: v[3] = m_to;
      5'h06: begin v[1] = m_sec; v[2] = m_boot; end
      5'h08: begin v[11] = m_halt; v[0] = m_nrb; end
      5'h12: v[9:0] = m_init;
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_step(input bit tk, input bit w, input logic [4:0] a, input logic [15:0] d);
    bit rl, cto, cse, cbo, ex, eff, sec;
    rl  = w && a == 5'h00;
    cto = w && a == 5'h04 && d[3];
    cse = w && a == 5'h06 && d[1];
    cbo = w && a == 5'h06 && d[2];
    ex  = tk && !m_halt && !rl && m_cnt == 0;
    eff = m_to && !cto;
    sec = ex && eff;
    m_rst = sec && !m_nrb;
    m_to = ex || eff;
    m_sec = sec || (m_sec && !cse);
    m_boot = sec || (m_boot && !cbo);
    if (rl || ex) m_cnt = m_init;
    else if (tk && !m_halt) m_cnt = m_cnt - 1'b1;
    if (w && a == 5'h08) begin m_halt = d[11]; m_nrb = d[0]; end
    if (w && a == 5'h12 && d[9:0] >= 10'd4) m_init = d[9:0];
  endtask

  task automatic cyc(input bit tk, input bit w, input logic [4:0] a,
                     input logic [15:0] d, input bit chk_rd, input string tag);
    logic [15:0] exp_rd;
    @(negedge clk);
    tick = tk; we = w; addr = a; wdata = d;
    exp_rd = model_read(a);
    @(posedge clk);
    model_step(tk, w, a, d);
    #1;
    if (rst_req) seen_rst++;
    check(rst_req === m_rst, "R7 rst_req", int'(rst_req), int'(m_rst));
    if (chk_rd) check(rdata === exp_rd, tag, int'(rdata), int'(exp_rd));
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d, input string tag);
    cyc(0, 1, a, d, 0, tag);
  endtask
  task automatic rd(input logic [4:0] a, input string tag);
    cyc(0, 0, a, 16'h0, 1, tag);
  endtask
  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1, 0, 5'h00, 16'h0, 1, tag);
  endtask
  task automatic tick_to_zero(input string tag);
    for (int i = 0; i < 2000 && m_cnt != 0; i++) cyc(1, 0, 5'h00, 16'h0, 1, tag);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int base;
    logic [4:0] ra;
    logic [15:0] rw;
    void'($urandom(32'd4711));
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(5'h00, "R1 count"); check(rdata == 16'd4, "R1 count fixed", rdata, 4);
    rd(5'h04, "R1 sts1"); rd(5'h06, "R1 sts2");
    rd(5'h08, "R1 ctrl"); check(rdata == 16'h0801, "R1 ctrl fixed", rdata, 16'h0801);
    rd(5'h12, "R1 init"); rd(5'h0c, "R2 unmapped");

    // R8 no-reboot readback, R6 init writes
    wr(5'h08, 16'h0800, "R8"); rd(5'h08, "R8 readback");
    check(rdata == 16'h0800, "R8 nrb cleared", rdata, 16'h0800);
    wr(5'h12, 16'h0002, "R6"); rd(5'h12, "R6 small ignored");
    check(rdata == 16'd4, "R6 kept", rdata, 4);
    wr(5'h12, 16'hfc05, "R6"); rd(5'h12, "R6 upper bits zero");
    check(rdata == 16'd5, "R6 value 5", rdata, 5);

    // R5 reload, R3 halt
    wr(5'h00, 16'h1234, "R5"); rd(5'h00, "R5 reload");
    check(rdata == 16'd5, "R5 count", rdata, 5);
    ticks(3, "R3 halted");
    rd(5'h00, "R3"); check(rdata == 16'd5, "R3 frozen", rdata, 5);
    wr(5'h08, 16'h0000, "R3 run");
    ticks(3, "R3 decrement");
    rd(5'h00, "R3"); check(rdata == 16'd2, "R3 count 2", rdata, 2);

    // R4 first expiry
    tick_to_zero("R4");
    ticks(1, "R4 expiry");
    rd(5'h04, "R4 sts1"); check(rdata == 16'h0008, "R4 flag", rdata, 8);
    rd(5'h00, "R4 reload"); check(rdata == 16'd5, "R4 reloaded", rdata, 5);

    // R9 write-one-to-clear
    wr(5'h04, 16'h0000, "R9"); rd(5'h04, "R9 zero no effect");
    wr(5'h04, 16'h0008, "R9"); rd(5'h04, "R9 cleared");
    check(rdata == 16'h0, "R9 flag clear", rdata, 0);

    // R7 two expiries -> pulse
    base = seen_rst;
    tick_to_zero("R7"); ticks(1, "R7 first");
    tick_to_zero("R7"); ticks(1, "R7 second");
    check(seen_rst == base + 1, "R7 one pulse", seen_rst - base, 1);
    rd(5'h06, "R7 sts2"); check(rdata == 16'h0006, "R7 flags", rdata, 6);

    // R11 clear versus set on second expiry
    base = seen_rst;
    tick_to_zero("R11");
    cyc(1, 1, 5'h06, 16'h0006, 1, "R11 collide");
    rd(5'h06, "R11 set wins"); check(rdata == 16'h0006, "R11 flags", rdata, 6);
    check(seen_rst == base + 1, "R11 pulse", seen_rst - base, 1);

    // R10 clear of timeout flag on the expiry cycle
    base = seen_rst;
    tick_to_zero("R10");
    cyc(1, 1, 5'h04, 16'h0008, 1, "R10 collide");
    rd(5'h04, "R10 flag"); check(rdata == 16'h0008, "R10 flag stays", rdata, 8);
    check(seen_rst == base, "R10 no pulse", seen_rst - base, 0);

    // R5 reload beats tick at zero
    tick_to_zero("R5");
    cyc(1, 1, 5'h00, 16'h0, 1, "R5 collide");
    check(seen_rst == base, "R5 no expiry", seen_rst - base, 0);

    // R8 gate
    wr(5'h08, 16'h0001, "R8");
    base = seen_rst;
    tick_to_zero("R8"); ticks(1, "R8"); tick_to_zero("R8"); ticks(1, "R8");
    check(seen_rst == base, "R8 blocked", seen_rst - base, 0);
    rd(5'h06, "R8 flags set");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      case ($urandom % 6)
        0: ra = 5'h00; 1: ra = 5'h04; 2: ra = 5'h06;
        3: ra = 5'h08; 4: ra = 5'h12; default: ra = 5'h0a;
      endcase
      rw = 16'($urandom);
      if (ra == 5'h08) rw[11] = ($urandom % 5 == 0);
      if (ra == 5'h12) rw[9:0] = 10'($urandom % 12);
      cyc(($urandom % 3) == 0, ($urandom % 25) == 0, ra, rw, 1, "R3 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule